// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block applies a series of test vectors to a full-scan sequential circuit. Each vector has a state part and a primary-input part. The block holds a parameterised K-bit scan chain with a hold enable. It shifts each state part into the chain serially through `scan_in`. It then spends one normal-mode cycle with `test_mode` low. In that cycle it drives the primary-input part and captures both the circuit's next-state lines and its primary outputs.

The response held in the chain leaves on `scan_out` while the next vector enters. The whole run therefore takes n(k+1)+k-1 clock edges for n vectors and a k-bit chain, instead of n(2k+1). For example, 4 vectors on a 2-bit chain need 13 edges.

The vector source is combinational. The block presents `vec_idx`, and the source answers in the same cycle with the state bits and primary-input bits of that vector. The circuit's combinational logic sits outside the block. It reads the chain through `chain_q` and returns its next-state lines on `chain_d` and its primary outputs on `po_in`. A run starts with a `start` pulse and ends with a sticky `done`.

Top module: `scan_test_seq`

## Requirements
- R1: A synchronous reset clears the chain to zero and returns the block to idle. After reset, `test_mode` is 1 and `done`, `so_valid`, `po_valid` and `pi_drive` are 0.
- R2: Cycles are counted from 0, starting with the first cycle after `start` is accepted. Vector v owns cycles v(K+1) to v(K+1)+K. During its first K cycles `test_mode` is 1 and the chain shifts one place towards bit K-1 on each edge. In shift cycle j, `scan_in` carries bit K-1-j of the vector state, so the most significant bit goes first. After these K shifts, `chain_q` equals the vector state.
- R3: Cycle v(K+1)+K is the capture cycle, and it is the only cycle of a vector with `test_mode` 0. In it `pi_drive` equals the vector's primary-input bits, and at its edge the chain loads `chain_d`. In every other cycle `pi_drive` is 0.
- R4: `po_in` is sampled at the capture edge. In the following cycle `po_valid` is 1 and `po_sample` holds the sampled value. `po_valid` is 0 in all other cycles.
- R5: `scan_out` always shows chain bit K-1. The response captured for vector v appears during the K cycles that follow its capture, bit K-1 first, and `so_valid` is 1 in exactly those cycles. For every vector except the last, these cycles are the shift cycles of vector v+1.
- R6: The last vector's capture is followed by exactly K-1 further shift edges. Its last response bit is presented in cycle n(K+1)+K-1, and no edge after that cycle shifts or captures.
- R7: `done` is 0 during a run and becomes 1 in the cycle after the last response bit. It stays 1 until a new `start` is accepted, and a `start` while done begins a fresh run from cycle 0.
- R8: `start` is ignored while a run is in progress. The cycle sequence and all outputs continue unchanged.
- R9: `vec_idx` equals the vector that owns the current cycle. During the final shift-out cycles it stays at n-1.
- R10: While idle or done, the chain holds its value whatever `chain_d` shows, and `test_mode` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle or done |
| vec_idx | output | $clog2(N_VEC) | Index of the vector requested from the source |
| vec_state | input | K_BITS | State part of the requested vector |
| vec_pi | input | L_PI | Primary-input part of the requested vector |
| test_mode | output | 1 | 1 = scan shift/hold, 0 = normal capture |
| scan_in | output | 1 | Serial bit entering chain bit 0 |
| scan_out | output | 1 | Serial bit leaving chain bit K-1 |
| so_valid | output | 1 | `scan_out` carries a response bit |
| chain_q | output | K_BITS | Present-state lines to the circuit logic |
| chain_d | input | K_BITS | Next-state lines from the circuit logic |
| pi_drive | output | L_PI | Primary-input drive |
| po_in | input | M_PO | Primary outputs of the circuit |
| po_sample | output | M_PO | Primary outputs captured at the last capture edge |
| po_valid | output | 1 | `po_sample` was updated at the previous edge |
| done | output | 1 | Run complete |

## Verification
The hardest situation to reach is the overlap itself. In the same cycle, one vector's captured response must be leaving on `scan_out` while the next vector's state enters on `scan_in`, and the two streams must never disturb each other. The bench makes this visible by using a circuit model whose next state mixes a rotation of the present state with the applied inputs plus a constant, so each response differs from its own vector. It then predicts every `scan_out` bit from the vector list alone. A `start` pulse in the middle of a run, a restart from the done state, and idle cycles in which `chain_d` is nonzero cover the remaining ordering and hold cases.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE} sq_state_e;

  // clock edges for a full run: n vectors of (k shifts + 1 capture), plus k-1 tail shifts
  function automatic int unsigned run_cycles(int unsigned n, int unsigned k);
    return n * (k + 1) + k - 1;
  endfunction
endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int K = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         cap_en,
  input  logic         ser_in,
  input  logic [K-1:0] par_in,
  output logic [K-1:0] q,
  output logic         ser_out
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (cap_en)   q <= par_in;
    else if (shift_en) q <= {q[K-2:0], ser_in};
  end

  assign ser_out = q[K-1];

  // R1
  chain_reset_chk: assert property (@(posedge clk) rst |=> q == '0);
  // R3
  chain_capture_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> q == $past(par_in));
  // R2
  chain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> q == {$past(q[K-2:0]), $past(ser_in)});
  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !cap_en) |=> $stable(q));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int N  = 4,
  parameter int K  = 2,
  parameter int PW = 2,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          running,
  output logic          in_vec,
  output logic          cap_cyc,
  output logic          shin_cyc,
  output logic          shift_cyc,
  output logic          resp_cyc,
  output logic          last_cyc,
  output logic          done,
  output logic [PW-1:0] pos,
  output logic [VW-1:0] vidx
);
  localparam int TOTAL = int'(run_cycles(N, K));
  localparam int CW    = $clog2(TOTAL + 2);

  sq_state_e     state;
  logic [CW-1:0] cnt;

  always_comb begin
    running   = (state == SQ_RUN);
    in_vec    = running && (vidx < VW'(N));
    cap_cyc   = in_vec && (pos == PW'(K));
    shin_cyc  = in_vec && (pos != PW'(K));
    last_cyc  = running && !in_vec && (cnt == CW'(TOTAL));
    shift_cyc = shin_cyc || (running && !in_vec && !last_cyc);
    resp_cyc  = (shin_cyc && (vidx != '0)) || (running && !in_vec);
    done      = (state == SQ_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      pos   <= '0;
      vidx  <= '0;
    end else begin
      case (state)
        SQ_RUN: begin
          if (last_cyc) begin
            state <= SQ_DONE;
          end else begin
            cnt <= cnt + 1'b1;
            if (in_vec) begin
              if (pos == PW'(K)) begin
                pos  <= '0;
                vidx <= vidx + 1'b1;
              end else begin
                pos <= pos + 1'b1;
              end
            end
          end
        end
        default: begin
          if (start) begin
            state <= SQ_RUN;
            cnt   <= '0;
            pos   <= '0;
            vidx  <= '0;
          end
        end
      endcase
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> int'(cnt) <= TOTAL);
  // R6
  tail_end_chk: assert property (@(posedge clk) disable iff (rst)
    last_cyc |=> (done && !running));
  // R3
  cap_single_chk: assert property (@(posedge clk) disable iff (rst)
    cap_cyc |=> !cap_cyc);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !last_cyc) |=> (running && int'(cnt) == int'($past(cnt)) + 1));
endmodule

// File: rtl/po_capture.sv
module po_capture #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [M-1:0] po_in,
  output logic [M-1:0] po_sample,
  output logic         po_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      po_sample <= '0;
      po_valid  <= 1'b0;
    end else begin
      po_valid <= cap_en;
      if (cap_en) po_sample <= po_in;
    end
  end

  // R4
  po_sample_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (po_valid && po_sample == $past(po_in)));
  // R4
  po_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> !po_valid);
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int N_VEC  = 4,
  parameter int K_BITS = 2,
  parameter int L_PI   = 3,
  parameter int M_PO   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  output logic [$clog2(N_VEC)-1:0]   vec_idx,
  input  logic [K_BITS-1:0]          vec_state,
  input  logic [L_PI-1:0]            vec_pi,
  output logic                       test_mode,
  output logic                       scan_in,
  output logic                       scan_out,
  output logic                       so_valid,
  output logic [K_BITS-1:0]          chain_q,
  input  logic [K_BITS-1:0]          chain_d,
  output logic [L_PI-1:0]            pi_drive,
  input  logic [M_PO-1:0]            po_in,
  output logic [M_PO-1:0]            po_sample,
  output logic                       po_valid,
  output logic                       done
);
  localparam int PW = $clog2(K_BITS + 1);
  localparam int VW = $clog2(N_VEC + 1);
  localparam int IW = $clog2(N_VEC);

  logic          running, in_vec, cap_cyc, shin_cyc, shift_cyc, resp_cyc, last_cyc;
  logic [PW-1:0] pos;
  logic [VW-1:0] vidx;
  logic [PW-1:0] bit_sel;
  logic [K_BITS-1:0] sel_word;

  seq_ctrl #(.N(N_VEC), .K(K_BITS), .PW(PW), .VW(VW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .running(running), .in_vec(in_vec), .cap_cyc(cap_cyc), .shin_cyc(shin_cyc),
    .shift_cyc(shift_cyc), .resp_cyc(resp_cyc), .last_cyc(last_cyc),
    .done(done), .pos(pos), .vidx(vidx)
  );

  // MSB of the vector state enters first so it ends up in the last flip-flop
  always_comb begin
    bit_sel  = PW'(K_BITS - 1) - pos;
    sel_word = vec_state >> bit_sel;
    scan_in  = shin_cyc ? sel_word[0] : 1'b0;
    vec_idx  = (vidx >= VW'(N_VEC)) ? IW'(N_VEC - 1) : vidx[IW-1:0];
    test_mode = !cap_cyc;
    pi_drive  = cap_cyc ? vec_pi : '0;
    so_valid  = resp_cyc;
  end

  scan_chain #(.K(K_BITS)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_cyc), .cap_en(cap_cyc),
    .ser_in(scan_in), .par_in(chain_d), .q(chain_q), .ser_out(scan_out)
  );

  po_capture #(.M(M_PO)) u_po (
    .clk(clk), .rst(rst), .cap_en(cap_cyc), .po_in(po_in),
    .po_sample(po_sample), .po_valid(po_valid)
  );

  // R2
  shin_mode_chk: assert property (@(posedge clk) disable iff (rst)
    shin_cyc |-> (test_mode && pi_drive == '0));
  // R10
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> (test_mode && !so_valid));
  // R5
  resp_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_cyc |=> so_valid);
endmodule

// File: tb/tb_scan_test_seq.sv
module tb_scan_test_seq;
  localparam int N = 5;
  localparam int K = 3;
  localparam int L = 3;
  localparam int M = 2;
  localparam int TOTAL = N * K + N + K - 1;

  logic clk = 1'b0;
  logic rst, start;
  logic [$clog2(N)-1:0] vec_idx;
  logic [K-1:0] vec_state, chain_q, chain_d;
  logic [L-1:0] vec_pi, pi_drive;
  logic [M-1:0] po_in, po_sample;
  logic test_mode, scan_in, scan_out, so_valid, po_valid, done;

  logic [K-1:0] st_mem [N];
  logic [L-1:0] pi_mem [N];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // circuit model outside the block
  function automatic logic [K-1:0] cut_next(logic [K-1:0] q, logic [L-1:0] p);
    return {q[0], q[K-1:1]} ^ p[K-1:0] ^ 3'b100;
  endfunction
  function automatic logic [M-1:0] cut_out(logic [K-1:0] q, logic [L-1:0] p);
    return {q[2] ^ p[1], q[0] & p[2]};
  endfunction

  assign vec_state = st_mem[vec_idx];
  assign vec_pi    = pi_mem[vec_idx];
  assign chain_d   = cut_next(chain_q, pi_drive);
  assign po_in     = cut_out(chain_q, pi_drive);

  scan_test_seq #(.N_VEC(N), .K_BITS(K), .L_PI(L), .M_PO(M)) dut (
    .clk(clk), .rst(rst), .start(start), .vec_idx(vec_idx),
    .vec_state(vec_state), .vec_pi(vec_pi), .test_mode(test_mode),
    .scan_in(scan_in), .scan_out(scan_out), .so_valid(so_valid),
    .chain_q(chain_q), .chain_d(chain_d), .pi_drive(pi_drive),
    .po_in(po_in), .po_sample(po_sample), .po_valid(po_valid), .done(done)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one full run, checked against a model that works only from cycle number and vector list
  task automatic run_and_check(bit poke_start);
    logic [K-1:0] resp [N];
    logic [M-1:0] outs [N];
    logic [K-1:0] held;
    for (int v = 0; v < N; v++) begin
      resp[v] = cut_next(st_mem[v], pi_mem[v]);
      outs[v] = cut_out(st_mem[v], pi_mem[v]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= TOTAL + 1; c++) begin
      int seg, p, pc;
      bit cap, pov, sov;
      seg = c / (K + 1);
      p   = c % (K + 1);
      cap = (c <= TOTAL) && (seg < N) && (p == K);
      sov = (c <= TOTAL) && (c >= K + 1) && (seg >= N || p < K);
      pc  = c - 1;
      pov = (c >= 1) && (pc % (K + 1) == K) && (pc / (K + 1) < N);
      check("R3", "test_mode", test_mode, !cap);
      check("R3", "pi_drive", pi_drive, cap ? pi_mem[seg] : 0);
      if (c <= TOTAL && seg < N && p < K)
        check("R2", "scan_in", scan_in, st_mem[seg][K-1-p]);
      if (cap) check("R2", "chain_q at capture", chain_q, st_mem[seg]);
      if (c <= TOTAL) check("R9", "vec_idx", vec_idx, (seg < N) ? seg : N - 1);
      check("R5", "so_valid", so_valid, sov);
      if (sov) check("R5", "scan_out", scan_out, resp[seg-1][K-1-p]);
      check("R4", "po_valid", po_valid, pov);
      if (pov) check("R4", "po_sample", po_sample, outs[pc / (K + 1)]);
      if (c == TOTAL) check("R6", "last bit presented", so_valid, 1);
      check("R7", "done", done, c == TOTAL + 1);
      if (poke_start && (c == 6 || c == TOTAL - 2)) start = 1'b1; // R8: ignored mid-run
      else start = 1'b0;
      @(negedge clk);
    end
    // R7 / R10: done holds, chain frozen although chain_d differs
    held = chain_q;
    for (int i = 0; i < 3; i++) begin
      check("R7", "done held", done, 1);
      check("R10", "chain held while done", chain_q, held);
      check("R10", "test_mode while done", test_mode, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    fails++;
    checks++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    st_mem[0] = 3'b101; st_mem[1] = 3'b011; st_mem[2] = 3'b110;
    st_mem[3] = 3'b000; st_mem[4] = 3'b111;
    pi_mem[0] = 3'b010; pi_mem[1] = 3'b111; pi_mem[2] = 3'b001;
    pi_mem[3] = 3'b100; pi_mem[4] = 3'b011;
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "chain_q", chain_q, 0);
    check("R1", "test_mode", test_mode, 1);
    check("R1", "done", done, 0);
    check("R1", "so_valid", so_valid, 0);
    check("R1", "po_valid", po_valid, 0);
    check("R1", "pi_drive", pi_drive, 0);
    // R10 idle: chain_d is nonzero here, the chain must not load it
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", "idle chain", chain_q, 0);
      check("R10", "idle test_mode", test_mode, 1);
    end
    run_and_check(1'b1);
    // second run restarted from done with a new vector set
    for (int v = 0; v < N; v++) begin
      st_mem[v] = K'(v * 3 + 1);
      pi_mem[v] = L'(7 - v);
    end
    run_and_check(1'b0);
    // reset in the middle of a run
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "chain after mid-run reset", chain_q, 0);
    check("R1", "done after mid-run reset", done, 0);
    check("R1", "so_valid after mid-run reset", so_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule